// File: doc/BRIEF.md
# Device Context Table Walker

This block turns a requester identifier (bus number plus device/function number) into a checked context entry. It reads a root table entry and then a context table entry over a simple quadword memory read port. After each fetch it applies the present, reserved-bit and mode-specific checks. It ends each walk with a one-cycle completion pulse, a status code and, on success, the context entry words.

The block walks in one of two table formats. In the legacy format, a 16-byte root entry points to 16-byte context entries indexed by the full device/function number. In the scalable format, the root entry carries two independent halves. The top bit of the device/function number picks the half, and each context entry is 32 bytes, or four quadwords. A feature input and a bit in the root table address input together choose the format at the start of each walk.

Top module: `ctx_walker`

## Requirements
- R1: A memory request holds `mem_req_valid` high with a stable, 8-byte aligned `mem_req_addr` until `mem_req_ready` is seen. Exactly one response beat returns per accepted request. Quadword k of an entry is read from the entry address plus 8*k.
- R2: The scalable format is used only when `scal_en` is 1 and `rtaddr[10]` is 1. Any other combination walks the legacy format.
- R3: The root entry address is `{rtaddr[63:12], 12'h000} + bus*16`. Quadword 0 is the low half and quadword 1 is the high half.
- R4: In the scalable format with `devfn[7]`=1, the high half supplies both the present bit (bit 0) and the context pointer (bits 63:12), and the context index is `devfn[6:0]`. In every other case the low half and the full `devfn` are used.
- R5: The context entry address is the pointer plus index times entry size. The entry size is 32 bytes (4 quadwords read) in the scalable format and 16 bytes (2 quadwords read) in the legacy format. In the legacy format, `ctx_q2` and `ctx_q3` report zero.
- R6: An error beat during the root fetch ends the walk with status 2. An error beat during the context fetch ends it with status 4.
- R7: A root entry whose selected present bit is 0 ends the walk with status 1 and `fault`=0, and no context fetch follows.
- R8: Root reserved bits are bits 11:1 and bits 63:MAW of a half (MAW=48 by default). In the legacy format, a nonzero high half or a reserved bit set in the low half gives status 3. In the scalable format, a reserved bit set in either half gives status 3.
- R9: A context entry with bit 0 of quadword 0 clear gives status 5.
- R10: The following context reserved bits give status 6 when any of them is set. Legacy format: quadword 0 bits 11:4 and 63:MAW, and quadword 1 bits 7:3 and 63:24. Scalable format: quadword 0 bits 11:2 and 63:MAW, quadword 1 bits 63:20, and any bit of quadwords 2 and 3.
- R11: In the legacy format only, the walk gives status 7 in either of two cases. The first is that the width code `aw`=quadword 1 bits 2:0 exceeds 4 or has `sagaw[aw]`=0. The second is that the type quadword 0 bits 3:2 equals 3, or equals 2 while `pt_ok`=0.
- R12: `done` is high for exactly one cycle per walk. `status` and `fault` hold from that cycle until the next walk ends, and `fault` is 1 for status 2 through 7. Status 0 means the entry is valid and `ctx_q0`..`ctx_q3` carry it.
- R13: The checks run in a fixed order: root fetch, root present, root reserved, context fetch, context present, context reserved, then the legacy level/type checks. The first failing check sets the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken when idle) |
| bus | input | 8 | Requester bus number |
| devfn | input | 8 | Requester device/function number |
| scal_en | input | 1 | Scalable format feature enable |
| rtaddr | input | 64 | Root table address register value; bit 10 selects the scalable format |
| sagaw | input | 5 | Supported width codes, one bit per `aw` value |
| pt_ok | input | 1 | Pass-through type is supported |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read quadword address |
| mem_rsp_valid | input | 1 | Read data beat valid |
| mem_rsp_data | input | 64 | Read data quadword |
| mem_rsp_err | input | 1 | Read beat failed |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last walk ended in a fault |
| status | output | 3 | Last walk result code |
| ctx_q0 | output | 64 | Context quadword 0 |
| ctx_q1 | output | 64 | Context quadword 1 |
| ctx_q2 | output | 64 | Context quadword 2 |
| ctx_q3 | output | 64 | Context quadword 3 |

## Verification
The bench targets five corner cases:

- **High device/function numbers in the scalable format.** A walker that consulted the wrong root half would report an absent root, or fetch a context entry from the wrong table. A walker that kept all eight index bits would miss its entry by 4 KB.
- **Mismatched mode inputs.** Either the feature on with the select bit clear, or the reverse, must still walk the legacy format. A design that decoded only one of the two would read four quadwords and misreport quadwords 2 and 3.
- **Order of overlapping faults.** One example is a nonzero legacy high half behind a clear present bit, which must report absent rather than reserved.
- **Fetch errors on the last beat.** These must abort the walk rather than deliver a partial entry.
- **The legacy pass-through and width-code limits.** An off-by-one there would accept an entry it must reject.

// File: rtl/ctx_walker.sv
module ctx_walker #(
  parameter int MAW      = 48,
  parameter int MODE_BIT = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  bus,
  input  logic [7:0]  devfn,
  input  logic        scal_en,
  input  logic [63:0] rtaddr,
  input  logic [4:0]  sagaw,
  input  logic        pt_ok,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [2:0]  status,
  output logic [63:0] ctx_q0,
  output logic [63:0] ctx_q1,
  output logic [63:0] ctx_q2,
  output logic [63:0] ctx_q3
);
  localparam logic [63:0] ABOVE_MAW  = ~((64'd1 << MAW) - 64'd1);
  localparam logic [63:0] ROOT_RSV   = ABOVE_MAW | 64'h0000_0000_0000_0FFE;
  localparam logic [63:0] LEG_Q0_RSV = ABOVE_MAW | 64'h0000_0000_0000_0FF0;
  localparam logic [63:0] LEG_Q1_RSV = 64'hFFFF_FFFF_FF00_00F8;
  localparam logic [63:0] SM_Q0_RSV  = ABOVE_MAW | 64'h0000_0000_0000_0FFC;
  localparam logic [63:0] SM_Q1_RSV  = 64'hFFFF_FFFF_FFF0_0000;

  localparam logic [2:0] ST_OK       = 3'd0;
  localparam logic [2:0] ST_ROOT_NP  = 3'd1;
  localparam logic [2:0] ST_ROOT_ERR = 3'd2;
  localparam logic [2:0] ST_ROOT_RSV = 3'd3;
  localparam logic [2:0] ST_CTX_ERR  = 3'd4;
  localparam logic [2:0] ST_CTX_NP   = 3'd5;
  localparam logic [2:0] ST_CTX_RSV  = 3'd6;
  localparam logic [2:0] ST_CTX_BAD  = 3'd7;

  typedef enum logic [2:0] {
    S_IDLE, S_RREQ, S_RRSP, S_RCHK, S_CREQ, S_CRSP, S_CCHK, S_FIN
  } state_t;

  state_t      state;
  logic [1:0]  beat;
  logic [7:0]  bus_r, devfn_r;
  logic        sm_r, pt_r;
  logic [4:0]  sag_r;
  logic [51:0] rbase_r;
  logic [63:0] rq0, rq1, cq0, cq1, cq2, cq3;
  logic [2:0]  st_r;
  logic        flt_r;

  logic        hi_sel;
  logic [63:0] rhalf, root_addr, ctx_addr;
  logic [7:0]  cidx, sag8;
  logic [2:0]  aw;
  logic [1:0]  last_cbeat;
  logic        root_bad, ctx_bad, lvl_bad, tt_bad;

  assign hi_sel     = sm_r & devfn_r[7];
  assign rhalf      = hi_sel ? rq1 : rq0;
  assign cidx       = hi_sel ? {1'b0, devfn_r[6:0]} : devfn_r;
  assign root_addr  = {rbase_r, 12'h000} + {52'd0, bus_r, 4'h0};
  assign ctx_addr   = {rhalf[63:12], 12'h000} +
                      (sm_r ? {51'd0, cidx, 5'd0} : {52'd0, cidx, 4'd0});
  assign last_cbeat = sm_r ? 2'd3 : 2'd1;

  assign mem_req_valid = (state == S_RREQ) || (state == S_CREQ);
  assign mem_req_addr  = ((state == S_RREQ) ? root_addr : ctx_addr) + {59'd0, beat, 3'd0};

  assign root_bad = sm_r ? (((rq0 | rq1) & ROOT_RSV) != 64'd0)
                         : ((rq1 != 64'd0) || ((rq0 & ROOT_RSV) != 64'd0));
  assign ctx_bad  = sm_r ? (((cq0 & SM_Q0_RSV) != 64'd0) || ((cq1 & SM_Q1_RSV) != 64'd0) ||
                            (cq2 != 64'd0) || (cq3 != 64'd0))
                         : (((cq0 & LEG_Q0_RSV) != 64'd0) || ((cq1 & LEG_Q1_RSV) != 64'd0));
  assign aw       = cq1[2:0];
  assign sag8     = {3'b000, sag_r};
  assign lvl_bad  = (aw > 3'd4) || !sag8[aw];
  assign tt_bad   = (cq0[3:2] == 2'b11) || ((cq0[3:2] == 2'b10) && !pt_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      beat    <= 2'd0;
      bus_r   <= 8'd0;
      devfn_r <= 8'd0;
      sm_r    <= 1'b0;
      pt_r    <= 1'b0;
      sag_r   <= 5'd0;
      rbase_r <= 52'd0;
      rq0     <= 64'd0;
      rq1     <= 64'd0;
      cq0     <= 64'd0;
      cq1     <= 64'd0;
      cq2     <= 64'd0;
      cq3     <= 64'd0;
      st_r    <= ST_OK;
      flt_r   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          bus_r   <= bus;
          devfn_r <= devfn;
          sm_r    <= scal_en & rtaddr[MODE_BIT];
          pt_r    <= pt_ok;
          sag_r   <= sagaw;
          rbase_r <= rtaddr[63:12];
          beat    <= 2'd0;
          state   <= S_RREQ;
        end
        S_RREQ: if (mem_req_ready) state <= S_RRSP;
        S_RRSP: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            st_r  <= ST_ROOT_ERR;
            flt_r <= 1'b1;
            state <= S_FIN;
          end else begin
            if (beat[0]) rq1 <= mem_rsp_data;
            else         rq0 <= mem_rsp_data;
            if (beat == 2'd1) state <= S_RCHK;
            else begin
              beat  <= beat + 2'd1;
              state <= S_RREQ;
            end
          end
        end
        S_RCHK: begin
          if (!rhalf[0]) begin
            st_r  <= ST_ROOT_NP;
            flt_r <= 1'b0;
            state <= S_FIN;
          end else if (root_bad) begin
            st_r  <= ST_ROOT_RSV;
            flt_r <= 1'b1;
            state <= S_FIN;
          end else begin
            beat  <= 2'd0;
            cq0   <= 64'd0;
            cq1   <= 64'd0;
            cq2   <= 64'd0;
            cq3   <= 64'd0;
            state <= S_CREQ;
          end
        end
        S_CREQ: if (mem_req_ready) state <= S_CRSP;
        S_CRSP: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            st_r  <= ST_CTX_ERR;
            flt_r <= 1'b1;
            state <= S_FIN;
          end else begin
            case (beat)
              2'd0: cq0 <= mem_rsp_data;
              2'd1: cq1 <= mem_rsp_data;
              2'd2: cq2 <= mem_rsp_data;
              default: cq3 <= mem_rsp_data;
            endcase
            if (beat == last_cbeat) state <= S_CCHK;
            else begin
              beat  <= beat + 2'd1;
              state <= S_CREQ;
            end
          end
        end
        S_CCHK: begin
          state <= S_FIN;
          flt_r <= 1'b1;
          if (!cq0[0])                          st_r <= ST_CTX_NP;
          else if (ctx_bad)                     st_r <= ST_CTX_RSV;
          else if (!sm_r && (lvl_bad || tt_bad)) st_r <= ST_CTX_BAD;
          else begin
            st_r  <= ST_OK;
            flt_r <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy   = (state != S_IDLE);
  assign done   = (state == S_FIN);
  assign fault  = flt_r;
  assign status = st_r;
  assign ctx_q0 = cq0;
  assign ctx_q1 = cq1;
  assign ctx_q2 = cq2;
  assign ctx_q3 = cq3;

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R1
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'd0);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  upper_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (status == ST_OK) |-> (ctx_q2 == 64'd0) && (ctx_q3 == 64'd0));

  // R7
  root_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (status == ST_ROOT_NP) |-> !fault);

  // R12
  status_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !$rose(done) && $past(!done) |-> $stable(status));
endmodule

// File: tb/tb_ctx_walker.sv
module tb_ctx_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  bus = 8'd0, devfn = 8'd0;
  logic        scal_en = 1'b0;
  logic [63:0] rtaddr = 64'd0;
  logic [4:0]  sagaw = 5'd0;
  logic        pt_ok = 1'b0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = 64'd0;
  logic        mem_rsp_err = 1'b0;
  logic        busy, done, fault;
  logic [2:0]  status;
  logic [63:0] ctx_q0, ctx_q1, ctx_q2, ctx_q3;

  localparam logic [63:0] HIGHM = 64'hFFFF_0000_0000_0000;
  localparam logic [63:0] RT_M  = HIGHM | 64'hFFE;
  localparam logic [63:0] LQ0_M = HIGHM | 64'hFF0;
  localparam logic [63:0] LQ1_M = 64'hFFFF_FFFF_FF00_00F8;
  localparam logic [63:0] SQ0_M = HIGHM | 64'hFFC;
  localparam logic [63:0] SQ1_M = 64'hFFFF_FFFF_FFF0_0000;
  localparam logic [63:0] DBASE = 64'h0000_0000_0010_0000;

  int checks = 0, errors = 0;

  ctx_walker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bus(bus), .devfn(devfn),
    .scal_en(scal_en), .rtaddr(rtaddr), .sagaw(sagaw), .pt_ok(pt_ok),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .busy(busy), .done(done), .fault(fault), .status(status),
    .ctx_q0(ctx_q0), .ctx_q1(ctx_q1), .ctx_q2(ctx_q2), .ctx_q3(ctx_q3));

  always #2 clk = ~clk;

  logic [63:0] mem [logic [63:0]];
  bit          errm [logic [63:0]];

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  bit pend = 0, stall_prev = 0;
  int lat = 0;
  logic [63:0] paddr, stall_addr;

  always @(negedge clk) begin
    if (!rst_n) begin
      pend = 0; stall_prev = 0;
      mem_rsp_valid = 0; mem_req_ready = 0;
    end else begin
      if (stall_prev)
        chk(mem_req_valid && mem_req_addr == stall_addr, "R1 request held until accepted",
            mem_req_addr, stall_addr);
      mem_rsp_valid = 0; mem_rsp_err = 0; mem_rsp_data = 64'd0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_err   = errm.exists(paddr);
          mem_rsp_data  = mem.exists(paddr) ? mem[paddr] : 64'd0;
          pend = 0;
        end else lat--;
      end
      mem_req_ready = pend ? 1'b0 : (($urandom % 4) != 0);
      stall_prev = mem_req_valid && !mem_req_ready;
      stall_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1; paddr = mem_req_addr; lat = $urandom % 3;
      end
    end
  end

  function automatic void rd(input logic [63:0] a, output logic [63:0] v, output bit e);
    e = errm.exists(a);
    v = mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic void ref_walk(output logic [2:0] st, output logic [63:0] w0, output logic [63:0] w1,
                                   output logic [63:0] w2, output logic [63:0] w3);
    logic [63:0] ra, lo, hi, half, ca, w[4];
    bit sm, up, e0, e1, ee;
    int nq;
    w0 = 0; w1 = 0; w2 = 0; w3 = 0;
    sm = scal_en && rtaddr[10];
    ra = {rtaddr[63:12], 12'h000} + 64'(bus) * 64'd16;
    rd(ra, lo, e0); rd(ra + 64'd8, hi, e1);
    if (e0 || e1) begin st = 3'd2; return; end
    up = sm && devfn[7];
    half = up ? hi : lo;
    if (!half[0]) begin st = 3'd1; return; end
    if (sm ? (((lo | hi) & RT_M) != 0) : (hi != 0 || (lo & RT_M) != 0)) begin st = 3'd3; return; end
    nq = sm ? 4 : 2;
    ca = {half[63:12], 12'h000} + 64'(up ? {1'b0, devfn[6:0]} : devfn) * 64'(sm ? 32 : 16);
    w[2] = 0; w[3] = 0;
    for (int k = 0; k < nq; k++) begin
      rd(ca + 64'(8 * k), w[k], ee);
      if (ee) begin st = 3'd4; return; end
    end
    w0 = w[0]; w1 = w[1]; w2 = w[2]; w3 = w[3];
    if (!w[0][0]) begin st = 3'd5; return; end
    if (sm ? (((w[0] & SQ0_M) != 0) || ((w[1] & SQ1_M) != 0) || w[2] != 0 || w[3] != 0)
           : (((w[0] & LQ0_M) != 0) || ((w[1] & LQ1_M) != 0))) begin st = 3'd6; return; end
    if (!sm && ((w[1][2:0] > 3'd4) || !sagaw[w[1][2:0]] || w[0][3:2] == 2'b11 ||
                (w[0][3:2] == 2'b10 && !pt_ok))) begin st = 3'd7; return; end
    st = 3'd0;
  endfunction

  task automatic walk(input string tag, input int exp_code);
    logic [2:0] rs, e;
    logic [63:0] r0, r1, r2, r3;
    int n;
    ref_walk(rs, r0, r1, r2, r3);
    e = (exp_code >= 0) ? 3'(exp_code) : rs;
    start = 1; @(negedge clk); start = 0;
    n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    if (!done) chk(0, {tag, " no completion (watchdog)"}, 0, 1);
    else begin
      chk(status == e, {tag, " status"}, 64'(status), 64'(e));
      chk(fault == (e > 3'd1), {tag, " R12 fault flag"}, 64'(fault), 64'(e > 3'd1));
      if (e == 3'd0) begin
        chk(ctx_q0 == r0, {tag, " ctx word0"}, ctx_q0, r0);
        chk(ctx_q1 == r1, {tag, " ctx word1"}, ctx_q1, r1);
        chk(ctx_q2 == r2, {tag, " ctx word2"}, ctx_q2, r2);
        chk(ctx_q3 == r3, {tag, " ctx word3"}, ctx_q3, r3);
      end
      @(negedge clk);
      chk(!done, "R12 done lasts one cycle", 64'(done), 0);
    end
  endtask

  task automatic dsetup(input bit se, input bit sb, input logic [7:0] b, input logic [7:0] df);
    mem.delete(); errm.delete();
    scal_en = se; rtaddr = DBASE | (64'(sb) << 10);
    bus = b; devfn = df; sagaw = 5'b00100; pt_ok = 0;
  endtask

  task automatic put_root(input logic [63:0] lo, input logic [63:0] hi);
    logic [63:0] a;
    a = DBASE + 64'(bus) * 64'd16;
    mem[a] = lo; mem[a + 64'd8] = hi;
  endtask

  task automatic put_ctx(input logic [63:0] ptr, input int idx, input int esz,
                         input logic [63:0] q0, input logic [63:0] q1,
                         input logic [63:0] q2, input logic [63:0] q3);
    logic [63:0] a;
    a = ptr + 64'(idx) * 64'(esz);
    mem[a] = q0; mem[a + 64'd8] = q1;
    if (esz == 32) begin mem[a + 64'd16] = q2; mem[a + 64'd24] = q3; end
  endtask

  localparam logic [63:0] LROOT = 64'h0000_0000_0020_0001;
  localparam logic [63:0] LQ0   = 64'h0000_0000_3000_0001;
  localparam logic [63:0] LQ1   = 64'h0000_0000_0000_1202;

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !busy && !mem_req_valid && status == 0 && !fault, "R12 reset state",
        {59'd0, done, busy, mem_req_valid, fault, 1'b0}, 0);

    // R3 R5 legacy success
    dsetup(0, 0, 8'h05, 8'h21); put_root(LROOT, 0);
    put_ctx(64'h20_0000, 8'h21, 16, LQ0, LQ1, 0, 0);
    mem[64'h20_0000 + 64'h21 * 16 + 16] = 64'hDEAD;
    walk("R3 R5 legacy walk", 0);
    // R7 root absent
    dsetup(0, 0, 8'h05, 8'h21); put_root(64'h20_0000, 0);
    walk("R7 root absent", 1);
    // R8 legacy high half nonzero
    dsetup(0, 0, 8'h05, 8'h21); put_root(LROOT, 64'h1);
    put_ctx(64'h20_0000, 8'h21, 16, LQ0, LQ1, 0, 0);
    walk("R8 legacy high half set", 3);
    dsetup(0, 0, 8'h05, 8'h21); put_root(LROOT | 64'h800, 0);
    walk("R8 legacy low reserved", 3);
    // R13 present beats reserved
    dsetup(0, 0, 8'h05, 8'h21); put_root(64'h20_0000, 64'h1);
    walk("R13 absent before reserved", 1);
    // R2 mode selection needs both
    dsetup(1, 0, 8'h07, 8'h21); put_root(LROOT, 0);
    put_ctx(64'h20_0000, 8'h21, 16, LQ0, LQ1, 0, 0);
    walk("R2 feature without select bit", 0);
    dsetup(0, 1, 8'h07, 8'h21); put_root(LROOT, 0);
    put_ctx(64'h20_0000, 8'h21, 16, LQ0, LQ1, 0, 0);
    walk("R2 select bit without feature", 0);
    // R4 scalable upper half
    dsetup(1, 1, 8'h33, 8'hC8); put_root(64'h0, 64'h0000_0000_0040_0001);
    put_ctx(64'h40_0000, 8'h48, 32, 64'h0000_0000_5000_0003, 64'h5, 0, 0);
    walk("R4 scalable upper half", 0);
    dsetup(1, 1, 8'h33, 8'h48); put_root(64'h0, 64'h0000_0000_0040_0001);
    walk("R4 scalable lower half absent", 1);
    dsetup(1, 1, 8'h33, 8'h48); put_root(64'h0000_0000_0040_0001, 64'h0000_0000_0060_0000);
    put_ctx(64'h40_0000, 8'h48, 32, 64'h0000_0000_5000_0001, 64'h9, 0, 0);
    walk("R4 scalable lower half", 0);
    dsetup(1, 1, 8'h33, 8'hC8); put_root(64'h2, 64'h0000_0000_0040_0001);
    walk("R8 scalable reserved in other half", 3);
    // R10 scalable quadword 3
    dsetup(1, 1, 8'h33, 8'hC8); put_root(64'h0, 64'h0000_0000_0040_0001);
    put_ctx(64'h40_0000, 8'h48, 32, 64'h0000_0000_5000_0001, 64'h5, 0, 64'h100);
    walk("R10 scalable word3 nonzero", 6);
    // R6 fetch errors
    dsetup(0, 0, 8'h05, 8'h21); put_root(LROOT, 0);
    errm[DBASE + 64'h05 * 16 + 8] = 1;
    walk("R6 root fetch error", 2);
    dsetup(1, 1, 8'h33, 8'hC8); put_root(64'h0, 64'h0000_0000_0040_0001);
    put_ctx(64'h40_0000, 8'h48, 32, 64'h0000_0000_5000_0001, 64'h5, 0, 0);
    errm[64'h40_0000 + 64'h48 * 32 + 24] = 1;
    walk("R6 context fetch error last beat", 4);
    // R11 legacy type and width
    dsetup(0, 0, 8'h05, 8'h21); put_root(LROOT, 0);
    put_ctx(64'h20_0000, 8'h21, 16, LQ0 | 64'h8, LQ1, 0, 0);
    walk("R11 pass-through unsupported", 7);
    pt_ok = 1;
    walk("R11 pass-through supported", 0);
    dsetup(0, 0, 8'h05, 8'h21); put_root(LROOT, 0);
    put_ctx(64'h20_0000, 8'h21, 16, LQ0 | 64'hC, LQ1, 0, 0);
    walk("R11 type 3", 7);
    dsetup(0, 0, 8'h05, 8'h21); put_root(LROOT, 0);
    put_ctx(64'h20_0000, 8'h21, 16, LQ0, 64'h1203, 0, 0);
    walk("R11 width not advertised", 7);
    sagaw = 5'b01000;
    walk("R11 width advertised", 0);
    dsetup(0, 0, 8'h05, 8'h21); sagaw = 5'b11111; put_root(LROOT, 0);
    put_ctx(64'h20_0000, 8'h21, 16, LQ0, 64'h1205, 0, 0);
    walk("R11 width code above 4", 7);
    // R9 R10 legacy context
    dsetup(0, 0, 8'h05, 8'h21); put_root(LROOT, 0);
    put_ctx(64'h20_0000, 8'h21, 16, LQ0 & ~64'h1, LQ1 | 64'h8, 0, 0);
    walk("R9 context absent", 5);
    dsetup(0, 0, 8'h05, 8'h21); put_root(LROOT, 0);
    put_ctx(64'h20_0000, 8'h21, 16, LQ0 | 64'h20, LQ1, 0, 0);
    walk("R10 legacy reserved", 6);
    // R4 R5 legacy high devfn uses full index
    dsetup(0, 0, 8'h09, 8'hC8); put_root(LROOT, 0);
    put_ctx(64'h20_0000, 8'hC8, 16, LQ0, LQ1, 0, 0);
    walk("R4 legacy high devfn", 0);

    for (int it = 0; it < 400; it++) begin
      logic [63:0] ra, rlo, rhi, ptr, ca, q[4];
      bit sm, up;
      int esz, nq;
      mem.delete(); errm.delete();
      scal_en = $urandom % 2;
      rtaddr = {$urandom, $urandom};
      bus = 8'($urandom); devfn = 8'($urandom);
      sagaw = 5'($urandom); pt_ok = $urandom % 2;
      sm = scal_en && rtaddr[10]; up = sm && devfn[7];
      ra = {rtaddr[63:12], 12'h000} + 64'(bus) * 64'd16;
      ptr = {$urandom, $urandom} & 64'h0000_FFFF_FFFF_F000;
      rlo = ({$urandom, $urandom} & 64'h0000_FFFF_FFFF_F000) | 64'(($urandom % 8) != 0);
      rhi = sm ? (({$urandom, $urandom} & 64'h0000_FFFF_FFFF_F000) | 64'(($urandom % 8) != 0))
               : ((($urandom % 8) == 0) ? {$urandom, $urandom} : 64'd0);
      if (up) rhi = ptr | 64'(($urandom % 8) != 0);
      else    rlo = ptr | 64'(($urandom % 8) != 0);
      if (($urandom % 8) == 0) rlo |= 64'd1 << ($urandom % 64);
      if (($urandom % 8) == 0) rhi |= 64'd1 << ($urandom % 64);
      mem[ra] = rlo; mem[ra + 64'd8] = rhi;
      esz = sm ? 32 : 16; nq = sm ? 4 : 2;
      ca = ptr + 64'(up ? {1'b0, devfn[6:0]} : devfn) * 64'(esz);
      q[0] = ({$urandom, $urandom} & 64'h0000_FFFF_FFFF_F000) |
             64'(($urandom % 10) != 0) | (sm ? 64'h2 : 64'(($urandom % 4) << 2));
      q[1] = sm ? 64'($urandom % 32'h10_0000) : (64'($urandom % 6) | (64'($urandom % 65536) << 8));
      q[2] = (($urandom % 8) == 0) ? {$urandom, $urandom} : 64'd0;
      q[3] = (($urandom % 8) == 0) ? {$urandom, $urandom} : 64'd0;
      if (($urandom % 6) == 0) q[$urandom % 2] |= 64'd1 << ($urandom % 64);
      for (int k = 0; k < 4; k++) mem[ca + 64'(8 * k)] = q[k];
      if (($urandom % 12) == 0) errm[ra + 64'(8 * ($urandom % 2))] = 1;
      if (($urandom % 12) == 0) errm[ca + 64'(8 * ($urandom % nq))] = 1;
      walk("R13 random walk", -1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule